// File: doc/BRIEF.md
# Pull-Style Flux Word Serializer

This block turns 16-bit parallel words into a serial stream of flux-transition pulses for a disk write channel. Each word is sent most-significant bit first. Every bit cell takes two ticks of a bit-cell enable. The first tick always marks a clock transition. The second tick marks a data transition only when the bit is 1.

The block pulls its data. After the sixteenth bit of a word has gone out, it raises a next-word request for exactly one clock cycle. It then waits, emitting nothing, until its controller answers with a one-cycle load strobe, which may come any number of cycles later. A load strobe that arrives while a word is still being shifted is dropped. This means a lost request or a lost strobe stops the stream for good, and the controller has to keep to the handshake. After reset the block sits idle until the first load strobe.

Top module: `flux_word_serializer`

## Requirements
- R1: After reset, and for as long as no word has been loaded, the block emits no transition pulse and no request, even while the bit-cell enable toggles.
- R2: A word is captured only on a clock edge where the load strobe is high and no word is being shifted. The enable is not acted on in that same cycle.
- R3: The bits of a captured word are sent most-significant bit first, so bit 15 goes in the first cell and bit 0 in the last.
- R4: The first enabled tick of every bit cell gives a transition pulse one clock cycle wide in the cycle after that tick.
- R5: The second enabled tick of a bit cell gives a transition pulse in the cycle after that tick if the bit is 1. If the bit is 0 it gives none.
- R6: The next-word request is high for exactly one cycle. That cycle is the cycle after the second tick of bit 0.
- R7: Once a word has finished, no further request and no transition pulse appear until a new word is loaded, whatever the enable does.
- R8: A load strobe that arrives while a word is being shifted has no effect. The word being sent and its timing are unchanged.
- R9: Cycles with the bit-cell enable low neither advance the cell sequence nor produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_en | input | 1 | Half-cell tick; two ticks make one bit cell |
| word_in | input | 16 | Parallel word, sampled on an accepted load strobe |
| load_stb | input | 1 | One-cycle load strobe from the controller |
| next_req | output | 1 | One-cycle request for the next word |
| flux_pulse | output | 1 | One-cycle pulse per flux transition |

## Verification
Both outputs come from registers. A transition pulse or a request caused by an enable tick at one rising edge is therefore due in the following cycle and in no other. A load strobe has no visible output of its own. It shows only through the pulses of the next cells. The bench drives inputs on the falling edge and samples at the next falling edge, one rising edge after the stimulus. In every cycle it compares both outputs with the value computed from the current word, bit index and cell half. Random gaps between ticks, stray load strobes during shifting and random stalls after each word make sure a pulse that comes early, late or extra shows up as a mismatch in some cycle.

// File: rtl/fsw_pkg.sv
// Package: shared types for the flux word serializer.
// Assumes: two half-cell ticks per bit cell.
package fsw_pkg;
    typedef enum logic {
        HALF_CLOCK = 1'b0,
        HALF_DATA  = 1'b1
    } cell_half_e;
endpackage

// File: rtl/fsw_cell_seq.sv
// Module: fsw_cell_seq
// Tracks whether a word is in flight, which half of the current bit cell
// comes next and how many bits have been sent. Decodes the slot strobes
// used by the shifter and the encoder.
// Assumes: load_stb and cell_en are synchronous to clk.
module fsw_cell_seq
    import fsw_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_en,
    input  logic load_stb,
    output logic capture,
    output logic clk_slot,
    output logic data_slot,
    output logic word_done,
    output logic busy
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    cell_half_e       half_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             busy_q;

    assign busy      = busy_q;
    assign capture   = load_stb && !busy_q;
    assign clk_slot  = busy_q && cell_en && (half_q == HALF_CLOCK);
    assign data_slot = busy_q && cell_en && (half_q == HALF_DATA);
    assign word_done = data_slot && (bit_cnt_q == LAST_BIT);

    // Step the cell half and the bit count, and start or end a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            half_q    <= HALF_CLOCK;
            bit_cnt_q <= '0;
        end else if (capture) begin
            busy_q    <= 1'b1;
            half_q    <= HALF_CLOCK;
            bit_cnt_q <= '0;
        end else if (clk_slot) begin
            half_q <= HALF_DATA;
        end else if (data_slot) begin
            half_q <= HALF_CLOCK;
            if (bit_cnt_q == LAST_BIT) begin
                busy_q <= 1'b0;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(bit_cnt_q) == LAST_BIT && $past(half_q) == HALF_DATA));

    // R9
    idle_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_en && !load_stb) |=> ($stable(half_q) && $stable(bit_cnt_q) && $stable(busy_q)));
endmodule

// File: rtl/fsw_word_reg.sv
// Module: fsw_word_reg
// Holds the word being sent and presents its next bit on the top bit.
// Shifts left after each data half so the MSB goes out first.
// Assumes: capture and advance are never high together.
module fsw_word_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              advance,
    input  logic [WORD_W-1:0] word_in,
    output logic              cur_bit
);
    logic [WORD_W-1:0] shreg_q;

    assign cur_bit = shreg_q[WORD_W-1];

    // Load a new word or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (capture) begin
            shreg_q <= word_in;
        end else if (advance) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
    end

    // R2
    exclusive_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && advance));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !advance) |=> $stable(shreg_q));
endmodule

// File: rtl/fsw_flux_enc.sv
// Module: fsw_flux_enc
// Registers the transition pulse and the next-word request.
// A clock half always gives a pulse; a data half gives one only for a 1.
// Assumes: the slot strobes are mutually exclusive.
module fsw_flux_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_slot,
    input  logic data_slot,
    input  logic data_bit,
    input  logic word_done,
    output logic flux_pulse,
    output logic next_req
);
    // Produce one-cycle output strobes from the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flux_pulse <= 1'b0;
            next_req   <= 1'b0;
        end else begin
            flux_pulse <= clk_slot || (data_slot && data_bit);
            next_req   <= word_done;
        end
    end

    // R4
    clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_slot |=> flux_pulse);

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_req |=> !next_req);
endmodule

// File: rtl/flux_word_serializer.sv
// Module: flux_word_serializer (top)
// Pull-style serializer: sends a word as flux transition pulses, asks for
// the next word with a one-cycle request and waits for a load strobe.
// Assumes: the controller answers each request with one load strobe.
module flux_word_serializer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load_stb,
    output logic              next_req,
    output logic              flux_pulse
);
    logic capture;
    logic clk_slot;
    logic data_slot;
    logic word_done;
    logic busy;
    logic cur_bit;

    fsw_cell_seq #(.WORD_W(WORD_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_en   (cell_en),
        .load_stb  (load_stb),
        .capture   (capture),
        .clk_slot  (clk_slot),
        .data_slot (data_slot),
        .word_done (word_done),
        .busy      (busy)
    );

    fsw_word_reg #(.WORD_W(WORD_W)) wreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .advance (data_slot),
        .word_in (word_in),
        .cur_bit (cur_bit)
    );

    fsw_flux_enc enc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_slot   (clk_slot),
        .data_slot  (data_slot),
        .data_bit   (cur_bit),
        .word_done  (word_done),
        .flux_pulse (flux_pulse),
        .next_req   (next_req)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !flux_pulse);

    // R7
    req_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_req |-> !busy);
endmodule

// File: tb/flux_word_serializer_tb.sv
// Bench: random gaps, stray strobes and stalls around directed words.
module flux_word_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_en = 1'b0;
    logic [15:0] word_in = '0;
    logic        load_stb = 1'b0;
    logic        next_req;
    logic        flux_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flux_word_serializer #(.WORD_W(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_en    (cell_en),
        .word_in    (word_in),
        .load_stb   (load_stb),
        .next_req   (next_req),
        .flux_pulse (flux_pulse)
    );

    // Expected pulse for a cell half: clock half always 1, data half = bit.
    function automatic logic exp_pulse(logic [15:0] w, int idx, bit data_half);
        return data_half ? w[idx] : 1'b1;
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, sample after the next rising edge.
    task automatic cyc(logic en, logic ld, logic [15:0] w);
        cell_en  = en;
        load_stb = ld;
        word_in  = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Send one word, checking every cycle until its request has been seen.
    task automatic send_word(logic [15:0] w, bit stray);
        cyc(1'b0, 1'b1, w);                              // R2 capture
        check("R2", flux_pulse, 1'b0, "pulse on load cycle");
        check("R2", next_req, 1'b0, "req on load cycle");
        for (int i = 15; i >= 0; i--) begin
            for (int h = 0; h < 2; h++) begin
                int gap = $urandom_range(0, 2);
                for (int g = 0; g < gap; g++) begin
                    logic ld = stray && ($urandom_range(0, 1) == 1);
                    cyc(1'b0, ld, 16'($urandom));        // R8 stray strobe, R9 no tick
                    check("R9", flux_pulse, 1'b0, "pulse without tick");
                    check("R8", next_req, 1'b0, "req mid word");
                end
                cyc(1'b1, 1'b0, 16'($urandom));
                // R3 MSB first, R4 clock half, R5 data half
                check(h == 0 ? "R4" : "R5", flux_pulse,
                      exp_pulse(w, i, h == 1), $sformatf("bit %0d half %0d", i, h));
                check("R6", next_req, (i == 0 && h == 1), "request timing");
            end
        end
    endtask

    // Cycles after a word ends with no load: nothing may come out.
    task automatic stall(int n);
        for (int k = 0; k < n; k++) begin
            cyc(1'($urandom_range(0, 1)), 1'b0, 16'($urandom));
            check("R7", flux_pulse, 1'b0, "pulse while stalled");
            check("R6", next_req, 1'b0, "request width");
        end
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", flux_pulse, 1'b0, "reset pulse");
        check("R1", next_req, 1'b0, "reset req");
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            cyc(1'($urandom_range(0, 1)), 1'b0, 16'hFFFF);
            check("R1", flux_pulse, 1'b0, "idle pulse");
            check("R1", next_req, 1'b0, "idle req");
        end
        send_word(16'h0000, 1'b0);
        stall(1);
        send_word(16'hFFFF, 1'b1);
        stall(6);
        send_word(16'h8001, 1'b1);
        send_word(16'h7FFE, 1'b0);                       // back to back after req
        stall(3);
        for (int n = 0; n < 30; n++) begin
            send_word(16'($urandom), 1'b1);
            stall($urandom_range(1, 8));
        end
        done = 1'b1;
    end

    initial begin
        int cyc_cnt = 0;
        while (!done && cyc_cnt < 100000) begin
            @(posedge clk);
            cyc_cnt++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule